// File: doc/BRIEF.md
# Ethernet DMA Register Bank

This block is the software-visible control and status store of an Ethernet DMA engine. A processor reaches it over a plain word-addressed bus, with a write strobe and a combinational read. It holds a bus configuration word, a control word whose enable bits go straight to the receive and transmit engines, an interrupt mask, a status word, and one base/current descriptor pointer pair for each ring. A read-only identification word is also visible.

The descriptor engines report events through two 2-bit pulse inputs, one per direction. Each event sets its completion or buffer-unavailable bit in the status word, and also the matching summary bit. Software acknowledges events by writing ones to the status word. A single level interrupt is raised while any masked-in status bit is set. The engines move their current descriptor pointers through step and wrap strobes: a step advances the pointer by one descriptor size, and a wrap returns it to the ring base. A write to the transmit kick location produces a one-cycle start pulse for the transmit engine.

Top module: `dmaregs_top`

## Requirements
- R1: After reset every register reads zero, the identification word reads 0x1012, and irq_o, rx_en_o, tx_en_o and tx_kick_o are low.
- R2: A write to the status word (word 4) clears each status bit whose written bit is one and leaves the other bits unchanged.
- R3: When an event sets a status bit in the same cycle that a write would clear it, the bit ends up set.
- R4: irq_o is high exactly when status AND interrupt mask (word 6) is nonzero.
- R5: A write to the receive base (word 2) or transmit base (word 3) loads that value into both the base and the matching current pointer. The current pointers read back at word 7 (receive) and word 8 (transmit), and they also drive rx_cur_o and tx_cur_o.
- R6: A step strobe adds DESC_BYTES to the current pointer. A step strobe with wrap set reloads the pointer from the ring base. A base write in the same cycle takes priority over both.
- R7: Word 9 always reads 0x1012, and writes to it have no effect.
- R8: A write to the bus configuration word (word 0) stores bit 0 as zero and keeps the other bits.
- R9: Control word (word 5) bit 1 drives rx_en_o and bit 13 drives tx_en_o.
- R10: A write to word 1 makes tx_kick_o high for exactly the following cycle, and word 1 always reads zero.
- R11: Event bits map to status bits as follows. tx_evt_i[0] sets bits 0 and 16. tx_evt_i[1] sets bits 2 and 15. rx_evt_i[0] sets bits 6 and 16. rx_evt_i[1] sets bits 7 and 15.
- R12: Word offsets outside 0 to 9 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| tx_evt_i | input | 2 | Transmit events: [0] done, [1] no buffer |
| rx_evt_i | input | 2 | Receive events: [0] done, [1] no buffer |
| rx_ptr_step_i | input | 1 | Advance receive current pointer |
| rx_ptr_wrap_i | input | 1 | With step: reload receive pointer from base |
| tx_ptr_step_i | input | 1 | Advance transmit current pointer |
| tx_ptr_wrap_i | input | 1 | With step: reload transmit pointer from base |
| rx_cur_o | output | DATA_W | Current receive descriptor pointer |
| tx_cur_o | output | DATA_W | Current transmit descriptor pointer |
| rx_en_o | output | 1 | Receive engine enable |
| tx_en_o | output | 1 | Transmit engine enable |
| tx_kick_o | output | 1 | One-cycle transmit start pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with DESC_BYTES set to 16 instead of the default 32. This shows that the pointer step follows the parameter and is not a fixed constant. ADDR_W is set to 5, so the bench can reach offsets 10 to 31 and show that the unmapped range reads zero and ignores writes. DATA_W stays at 32, which keeps both summary bits and control bit 13 in range.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  // word offsets
  localparam int W_BUSCFG  = 0;
  localparam int W_TXKICK  = 1;
  localparam int W_RXBASE  = 2;
  localparam int W_TXBASE  = 3;
  localparam int W_STATUS  = 4;
  localparam int W_CTRL    = 5;
  localparam int W_IRQMASK = 6;
  localparam int W_RXCUR   = 7;
  localparam int W_TXCUR   = 8;
  localparam int W_IDENT   = 9;

  // status bit positions
  localparam int S_TX_DONE  = 0;
  localparam int S_TX_NOBUF = 2;
  localparam int S_RX_DONE  = 6;
  localparam int S_RX_NOBUF = 7;
  localparam int S_ABNORMAL = 15;
  localparam int S_NORMAL   = 16;

  // control bit positions
  localparam int C_RX_EN = 1;
  localparam int C_TX_EN = 13;

  localparam logic [31:0] IDENT_WORD = 32'h0000_1012;

  localparam int RING_RX = 0;
  localparam int RING_TX = 1;
  localparam int N_RINGS = 2;
endpackage

// File: rtl/dmaregs_status.sv
module dmaregs_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] set_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, status_n;
  logic [DATA_W-1:0] mask_q;
  logic              status_we;

  always_comb begin
    status_n = status_q;
    if (clr_en_i) status_n = status_n & ~wdata_i;
    status_n  = status_n | set_i;           // set beats clear
    status_we = clr_en_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_we) begin
      status_q <= status_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/dmaregs_ring.sv
module dmaregs_ring #(
  parameter int DATA_W     = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic              wrap_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] cur_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DESC_BYTES);

  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] cur_q, cur_n;
  logic              cur_we;

  always_comb begin
    cur_n  = cur_q;
    cur_we = base_we_i | step_i;
    if (base_we_i)   cur_n = wdata_i;
    else if (wrap_i) cur_n = base_q;
    else             cur_n = cur_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we_i) begin
      base_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_we) begin
      cur_q <= cur_n;
    end
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/dmaregs_top.sv
module dmaregs_top
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        tx_evt_i,
  input  logic [1:0]        rx_evt_i,
  input  logic              rx_ptr_step_i,
  input  logic              rx_ptr_wrap_i,
  input  logic              tx_ptr_step_i,
  input  logic              tx_ptr_wrap_i,
  output logic [DATA_W-1:0] rx_cur_o,
  output logic [DATA_W-1:0] tx_cur_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              tx_kick_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] IDENT = DATA_W'(IDENT_WORD);

  // write decode
  logic sel_bus, sel_kick, sel_status, sel_ctrl, sel_mask;
  logic [N_RINGS-1:0] sel_base;

  always_comb begin
    sel_bus    = wr_en_i && (addr_i == ADDR_W'(W_BUSCFG));
    sel_kick   = wr_en_i && (addr_i == ADDR_W'(W_TXKICK));
    sel_status = wr_en_i && (addr_i == ADDR_W'(W_STATUS));
    sel_ctrl   = wr_en_i && (addr_i == ADDR_W'(W_CTRL));
    sel_mask   = wr_en_i && (addr_i == ADDR_W'(W_IRQMASK));
    sel_base[RING_RX] = wr_en_i && (addr_i == ADDR_W'(W_RXBASE));
    sel_base[RING_TX] = wr_en_i && (addr_i == ADDR_W'(W_TXBASE));
  end

  // event to status-bit mapping
  logic [DATA_W-1:0] set_mask;
  always_comb begin
    set_mask = '0;
    if (tx_evt_i[0]) begin set_mask[S_TX_DONE]  = 1'b1; set_mask[S_NORMAL]   = 1'b1; end
    if (tx_evt_i[1]) begin set_mask[S_TX_NOBUF] = 1'b1; set_mask[S_ABNORMAL] = 1'b1; end
    if (rx_evt_i[0]) begin set_mask[S_RX_DONE]  = 1'b1; set_mask[S_NORMAL]   = 1'b1; end
    if (rx_evt_i[1]) begin set_mask[S_RX_NOBUF] = 1'b1; set_mask[S_ABNORMAL] = 1'b1; end
  end

  logic [DATA_W-1:0] status_q, mask_q;

  dmaregs_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_en_i  (sel_status),
    .mask_we_i (sel_mask),
    .wdata_i   (wdata_i),
    .set_i     (set_mask),
    .status_o  (status_q),
    .mask_o    (mask_q),
    .irq_o     (irq_o)
  );

  // descriptor rings
  logic [N_RINGS-1:0] ring_step, ring_wrap;
  logic [DATA_W-1:0]  ring_base [N_RINGS];
  logic [DATA_W-1:0]  ring_cur  [N_RINGS];

  assign ring_step[RING_RX] = rx_ptr_step_i;
  assign ring_wrap[RING_RX] = rx_ptr_wrap_i;
  assign ring_step[RING_TX] = tx_ptr_step_i;
  assign ring_wrap[RING_TX] = tx_ptr_wrap_i;

  for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
    dmaregs_ring #(.DATA_W(DATA_W), .DESC_BYTES(DESC_BYTES)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we_i (sel_base[g]),
      .wdata_i   (wdata_i),
      .step_i    (ring_step[g]),
      .wrap_i    (ring_wrap[g]),
      .base_o    (ring_base[g]),
      .cur_o     (ring_cur[g])
    );
  end

  assign rx_cur_o = ring_cur[RING_RX];
  assign tx_cur_o = ring_cur[RING_TX];

  // bus configuration and control words
  logic [DATA_W-1:0] buscfg_q, buscfg_n;
  logic [DATA_W-1:0] ctrl_q;
  logic              kick_q;

  always_comb begin
    buscfg_n    = wdata_i;
    buscfg_n[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buscfg_q <= '0;
    end else if (sel_bus) begin
      buscfg_q <= buscfg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (sel_ctrl) begin
      ctrl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_q <= 1'b0;
    end else begin
      kick_q <= sel_kick;
    end
  end

  assign rx_en_o   = ctrl_q[C_RX_EN];
  assign tx_en_o   = ctrl_q[C_TX_EN];
  assign tx_kick_o = kick_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(W_BUSCFG):  rdata_o = buscfg_q;
      ADDR_W'(W_RXBASE):  rdata_o = ring_base[RING_RX];
      ADDR_W'(W_TXBASE):  rdata_o = ring_base[RING_TX];
      ADDR_W'(W_STATUS):  rdata_o = status_q;
      ADDR_W'(W_CTRL):    rdata_o = ctrl_q;
      ADDR_W'(W_IRQMASK): rdata_o = mask_q;
      ADDR_W'(W_RXCUR):   rdata_o = ring_cur[RING_RX];
      ADDR_W'(W_TXCUR):   rdata_o = ring_cur[RING_TX];
      ADDR_W'(W_IDENT):   rdata_o = IDENT;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dmaregs_chk.sv
module dmaregs_chk
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [1:0]        tx_evt_i,
  input logic [1:0]        rx_evt_i,
  input logic [DATA_W-1:0] rx_cur_o,
  input logic [DATA_W-1:0] status_q,
  input logic              tx_kick_o,
  input logic              irq_o
);
  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(W_STATUS) && tx_evt_i == 2'b00 && rx_evt_i == 2'b00)
    |=> ((status_q & $past(wdata_i)) == '0));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt_i[0] |=> (status_q[S_TX_DONE] && status_q[S_NORMAL]));

  assert_mask_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(W_IRQMASK) && wdata_i == '0) |=> !irq_o);

  assert_base_loads_cur_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(W_RXBASE)) |=> (rx_cur_o == $past(wdata_i)));

  assert_ident_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(W_IDENT)) |-> (rdata_o == DATA_W'(IDENT_WORD)));

  assert_kick_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(W_TXKICK)) |=> tx_kick_o);

  assert_kick_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(W_TXKICK)) |=> !tx_kick_o);
endmodule

bind dmaregs_top dmaregs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dmaregs_top.sv
module tb_dmaregs_top;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int DB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [1:0]    tx_evt = 2'b00, rx_evt = 2'b00;
  logic          rx_step = 1'b0, rx_wrap = 1'b0, tx_step = 1'b0, tx_wrap = 1'b0;
  logic [DW-1:0] rx_cur, tx_cur;
  logic          rx_en, tx_en, tx_kick, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dmaregs_top #(.ADDR_W(AW), .DATA_W(DW), .DESC_BYTES(DB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .rx_ptr_step_i(rx_step), .rx_ptr_wrap_i(rx_wrap),
    .tx_ptr_step_i(tx_step), .tx_ptr_wrap_i(tx_wrap),
    .rx_cur_o(rx_cur), .tx_cur_o(tx_cur), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .tx_kick_o(tx_kick), .irq_o(irq)
  );

  // scoreboard of expected read values
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s read: actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic rd(input int a, input logic [DW-1:0] e, input string t);
    @(posedge clk); #1;
    addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic pulse_evt(input logic [1:0] tx, input logic [1:0] rx);
    @(posedge clk); #1;
    tx_evt = tx; rx_evt = rx;
    @(posedge clk); #1;
    tx_evt = 2'b00; rx_evt = 2'b00;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", DW'(irq), 0);
    chk("R1 rx_en", DW'(rx_en), 0);
    chk("R1 tx_en", DW'(tx_en), 0);
    chk("R1 tx_kick", DW'(tx_kick), 0);
    for (int i = 0; i < 9; i++) rd(i, 0, "R1 reset reg");
    rd(9, 32'h1012, "R1 ident");

    // R9 control enables
    wr(5, 32'h0000_0002);
    @(negedge clk);
    chk("R9 rx_en set", DW'(rx_en), 1);
    chk("R9 tx_en clear", DW'(tx_en), 0);
    wr(5, 32'h0000_2000);
    @(negedge clk);
    chk("R9 rx_en clear", DW'(rx_en), 0);
    chk("R9 tx_en set", DW'(tx_en), 1);

    // R8 bus config bit 0
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'hFFFF_FFFE, "R8 bit0 forced zero");

    // R7 ident ignores writes
    wr(9, 32'hDEAD_BEEF);
    rd(9, 32'h1012, "R7 ident after write");

    // R12 unmapped
    wr(20, 32'h1234_5678);
    rd(20, 0, "R12 unmapped reads zero");
    for (int i = 0; i < 9; i++) if (i != 0 && i != 5) rd(i, 0, "R12 no side effect");

    // R5 base loads current pointer
    wr(2, 32'h0000_1000);
    rd(7, 32'h0000_1000, "R5 rx cur read");
    @(negedge clk); chk("R5 rx_cur_o", rx_cur, 32'h0000_1000);
    wr(3, 32'h0000_2000);
    rd(8, 32'h0000_2000, "R5 tx cur read");
    rd(2, 32'h0000_1000, "R5 rx base kept");

    // R6 step and wrap
    @(posedge clk); #1 rx_step = 1'b1;
    @(posedge clk); #1 rx_step = 1'b0;
    @(negedge clk); chk("R6 rx step", rx_cur, 32'h0000_1000 + DB);
    @(posedge clk); #1 tx_step = 1'b1;
    @(posedge clk); @(posedge clk); #1 tx_step = 1'b0;
    @(negedge clk); chk("R6 tx step x2", tx_cur, 32'h0000_2000 + 2 * DB);
    @(posedge clk); #1 rx_step = 1'b1; rx_wrap = 1'b1;
    @(posedge clk); #1 rx_step = 1'b0; rx_wrap = 1'b0;
    @(negedge clk); chk("R6 rx wrap", rx_cur, 32'h0000_1000);
    // base write beats step in same cycle
    @(posedge clk); #1 tx_step = 1'b1; wr_en = 1'b1; addr = 3; wdata = 32'h0000_3000;
    @(posedge clk); #1 tx_step = 1'b0; wr_en = 1'b0;
    @(negedge clk); chk("R6 base write priority", tx_cur, 32'h0000_3000);

    // R11 event bit mapping
    pulse_evt(2'b01, 2'b00);
    rd(4, 32'h0001_0001, "R11 tx done");
    wr(4, 32'hFFFF_FFFF);
    pulse_evt(2'b10, 2'b00);
    rd(4, 32'h0000_8004, "R11 tx nobuf");
    wr(4, 32'hFFFF_FFFF);
    pulse_evt(2'b00, 2'b01);
    rd(4, 32'h0001_0040, "R11 rx done");
    wr(4, 32'hFFFF_FFFF);
    pulse_evt(2'b00, 2'b10);
    rd(4, 32'h0000_8080, "R11 rx nobuf");
    wr(4, 32'hFFFF_FFFF);
    rd(4, 0, "R2 clear all");

    // R4 interrupt with mask
    pulse_evt(2'b01, 2'b00);
    @(negedge clk); chk("R4 masked off", DW'(irq), 0);
    wr(6, 32'h0000_0001);
    @(negedge clk); chk("R4 mask enables irq", DW'(irq), 1);

    // R2 partial clear
    wr(4, 32'h0000_0001);
    rd(4, 32'h0001_0000, "R2 partial clear");
    @(negedge clk); chk("R4 irq drops", DW'(irq), 0);
    wr(4, 32'h0001_0000);
    rd(4, 0, "R2 second clear");

    // R3 set wins over clear
    @(posedge clk); #1 wr_en = 1'b1; addr = 4; wdata = 32'hFFFF_FFFF; rx_evt = 2'b01;
    @(posedge clk); #1 wr_en = 1'b0; rx_evt = 2'b00;
    rd(4, 32'h0001_0040, "R3 set beats clear");
    wr(4, 32'hFFFF_FFFF);

    // R10 kick pulse
    wr(1, 32'hFFFF_FFFF);
    @(negedge clk); chk("R10 kick high", DW'(tx_kick), 1);
    @(negedge clk); chk("R10 kick one cycle", DW'(tx_kick), 0);
    rd(1, 0, "R10 kick reads zero");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule